// File: doc/BRIEF.md
# Subvector Transpose Index Sequencer

This block walks a vector loop of `vl` elements. Each element holds `sub_len_m1 + 1` sub-elements. On every accepted step it presents one pair of offsets: a source offset and a destination offset. Each side runs its own two-level loop, and a per-side order bit picks which loop is outer. Offsets are always formed as `i*S + j`, where `i` is the element index, `j` the sub-element index and `S` the subvector length. When the two sides use different orders, the stream of pairs moves data as a transpose of the sub-element grid. A downstream mover reads at `src_off` and writes at `dst_off`.

A one-cycle `start` pulse in idle latches the configuration. The block then emits pairs while `valid` is high and moves forward on each cycle where `stall` is low. It raises `last` with the final pair and pulses `done` one cycle after that pair is accepted.

The controller has three states:
- IDLE: waiting for `start`. A start with `vl = 0` goes to FINISH; any other start goes to RUN.
- RUN: presents pairs. Acceptance of the last pair moves it to FINISH.
- FINISH: pulses `done` for one cycle, then always returns to IDLE.

Top module: `subvec_xpose_seq`

## Requirements
- R1: After reset, `valid`, `last`, `done` and `busy` are all low.
- R2: With `pack_src = 0`, the k-th source offset (counting from 0) equals k, which is element-outer order.
- R3: With `unpack_dst = 0`, the k-th destination offset equals k.
- R4: With `pack_src = 1`, the source side runs sub-element-outer order, so step k gives `(k mod VL)*S + k div VL`. For VL=2 and S=3 this is 0,3,1,4,2,5.
- R5: With `unpack_dst = 1`, the destination side uses the same swapped order as R4.
- R6: Setting both order bits is legal, and both sides then produce the swapped sequence.
- R7: `sub_len_m1` encodes S as value+1: 0→1, 1→2, 2→3, 3→4. Exactly VL*S pairs are emitted, and every offset is below VL*S.
- R8: `last` is high only together with the final pair. `done` is high for exactly the one cycle after that pair is accepted, and the block is idle on the cycle after that.
- R9: A start with VL=0 emits no pair, and `done` is high in the cycle after `start`.
- R10: While `stall` is high, the presented pair and `valid` hold unchanged.
- R11: A `start` pulse while busy is ignored: the running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (accepted only in idle) |
| vl | input | VL_W | Element count |
| sub_len_m1 | input | 2 | Subvector length minus one |
| pack_src | input | 1 | Swap the loop order on the source side |
| unpack_dst | input | 1 | Swap the loop order on the destination side |
| stall | input | 1 | Hold the current pair |
| valid | output | 1 | A pair is presented |
| src_off | output | VL_W+2 | Source offset |
| dst_off | output | VL_W+2 | Destination offset |
| last | output | 1 | The presented pair is the final one |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Not idle |

## Verification
The bench builds the block with the default `VL_W = 6`, so VL can reach 63. With S=4 this takes offsets up to 251, which covers the full offset width and the `i == VL-1` wrap on the swapped side at its largest.

The same build also covers VL=0, VL=1 and odd lengths. The stall and restart patterns are applied at points where a counter is about to wrap.

// File: rtl/subvec_xpose_pkg.sv
package subvec_xpose_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } seq_state_t;
endpackage

// File: rtl/sxp_nest_counter.sv
// Two-level loop counter; swap selects which index is the outer one.
module sxp_nest_counter #(
    parameter int VL_W  = 6,
    parameter int OFF_W = VL_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic             swap,
    input  logic [VL_W-1:0]  vl,
    input  logic [1:0]       sub_m1,
    output logic [OFF_W-1:0] off
);
    logic [VL_W-1:0] i_q;
    logic [1:0]      j_q;
    logic [2:0]      sub_len;

    assign sub_len = {1'b0, sub_m1} + 3'd1;
    assign off     = OFF_W'(i_q) * OFF_W'(sub_len) + OFF_W'(j_q);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            i_q <= '0;
            j_q <= '0;
        end else if (step) begin
            if (swap) begin
                if (i_q == vl - VL_W'(1)) begin
                    i_q <= '0;
                    j_q <= j_q + 2'd1;
                end else begin
                    i_q <= i_q + VL_W'(1);
                end
            end else begin
                if (j_q == sub_m1) begin
                    j_q <= '0;
                    i_q <= i_q + VL_W'(1);
                end else begin
                    j_q <= j_q + 2'd1;
                end
            end
        end
    end
endmodule

// File: rtl/sxp_ctrl.sv
module sxp_ctrl
    import subvec_xpose_pkg::*;
#(
    parameter int VL_W  = 6,
    parameter int OFF_W = VL_W + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [VL_W-1:0] vl,
    input  logic [1:0]      sub_m1,
    input  logic            pack,
    input  logic            unpack,
    input  logic            stall,
    output logic            load,
    output logic            adv,
    output logic            valid,
    output logic            last,
    output logic            done,
    output logic            busy,
    output logic [VL_W-1:0] vl_q,
    output logic [1:0]      sub_q,
    output logic            pack_q,
    output logic            unpack_q
);
    seq_state_t       state, nxt;
    logic [OFF_W-1:0] step_cnt;
    logic [OFF_W-1:0] total_q;
    logic             final_step;

    assign final_step = (step_cnt == total_q - OFF_W'(1));

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = (vl == '0) ? ST_FINISH : ST_RUN;
            ST_RUN:    if (!stall && final_step) nxt = ST_FINISH;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            step_cnt <= '0;
            total_q  <= '0;
            vl_q     <= '0;
            sub_q    <= '0;
            pack_q   <= 1'b0;
            unpack_q <= 1'b0;
        end else begin
            state <= nxt;
            if (load) begin
                step_cnt <= '0;
                total_q  <= OFF_W'(vl) * OFF_W'({1'b0, sub_m1} + 3'd1);
                vl_q     <= vl;
                sub_q    <= sub_m1;
                pack_q   <= pack;
                unpack_q <= unpack;
            end else if (adv) begin
                step_cnt <= step_cnt + OFF_W'(1);
            end
        end
    end

    always_comb begin
        valid = (state == ST_RUN);
        busy  = (state != ST_IDLE);
        done  = (state == ST_FINISH);
        load  = (state == ST_IDLE) && start;
        adv   = valid && !stall;
        last  = valid && final_step;
    end

    AST_FINISH_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FINISH) |=> (state == ST_IDLE)); // R8
endmodule

// File: rtl/subvec_xpose_seq.sv
module subvec_xpose_seq #(
    parameter int VL_W = 6,
    localparam int OFF_W = VL_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VL_W-1:0]  vl,
    input  logic [1:0]       sub_len_m1,
    input  logic             pack_src,
    input  logic             unpack_dst,
    input  logic             stall,
    output logic             valid,
    output logic [OFF_W-1:0] src_off,
    output logic [OFF_W-1:0] dst_off,
    output logic             last,
    output logic             done,
    output logic             busy
);
    logic            load, adv;
    logic [VL_W-1:0] vl_q;
    logic [1:0]      sub_q;
    logic            pack_q, unpack_q;
    logic [OFF_W-1:0] side_off [2];

    sxp_ctrl #(.VL_W(VL_W), .OFF_W(OFF_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .sub_m1(sub_len_m1),
        .pack(pack_src), .unpack(unpack_dst), .stall(stall),
        .load(load), .adv(adv), .valid(valid), .last(last), .done(done),
        .busy(busy), .vl_q(vl_q), .sub_q(sub_q), .pack_q(pack_q),
        .unpack_q(unpack_q)
    );

    // side 0 = source (pack order), side 1 = destination (unpack order)
    for (genvar g = 0; g < 2; g++) begin : g_side
        sxp_nest_counter #(.VL_W(VL_W), .OFF_W(OFF_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .clr(load), .step(adv),
            .swap((g == 0) ? pack_q : unpack_q),
            .vl(vl_q), .sub_m1(sub_q), .off(side_off[g])
        );
    end

    assign src_off = side_off[0];
    assign dst_off = side_off[1];

    AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> valid); // R8
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && last && !stall) |=> (done && !valid)); // R8
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && stall) |=> (valid && $stable(src_off) && $stable(dst_off))); // R10
    AST_OFF_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (src_off < OFF_W'(vl_q) * OFF_W'({1'b0, sub_q} + 3'd1)
                && dst_off < OFF_W'(vl_q) * OFF_W'({1'b0, sub_q} + 3'd1))); // R7
    AST_FIRST_PAIR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> (src_off == '0 && dst_off == '0)); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R9
endmodule

// File: tb/subvec_xpose_seq_tb.sv
module subvec_xpose_seq_tb;
    localparam int VL_W  = 6;
    localparam int OFF_W = VL_W + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [VL_W-1:0] vl = '0;
    logic [1:0] sub_len_m1 = '0;
    logic pack_src = 1'b0, unpack_dst = 1'b0, stall = 1'b0;
    logic valid, last, done, busy;
    logic [OFF_W-1:0] src_off, dst_off;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    subvec_xpose_seq #(.VL_W(VL_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .sub_len_m1(sub_len_m1),
        .pack_src(pack_src), .unpack_dst(unpack_dst), .stall(stall),
        .valid(valid), .src_off(src_off), .dst_off(dst_off), .last(last),
        .done(done), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int ref_off(input int k, input bit swap, input int n, input int s);
        if (!swap) return k;
        return (k % n) * s + k / n;
    endfunction

    // Behavioural reference: a queue of expected pairs, popped on acceptance.
    task automatic run_seq(input int n, input int m1, input bit pk, input bit up,
                           input bit use_stall, input bit poke);
        int s = m1 + 1;
        int total = n * s;
        int q_src[$];
        int q_dst[$];
        int cyc = 0;
        bit was_stalled = 0;
        for (int k = 0; k < total; k++) begin
            q_src.push_back(ref_off(k, pk, n, s));
            q_dst.push_back(ref_off(k, up, n, s));
        end
        @(negedge clk);
        vl = VL_W'(n); sub_len_m1 = 2'(m1); pack_src = pk; unpack_dst = up;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        if (n == 0) begin
            chk(done == 1'b1, "R9 done after empty start", int'(done), 1);
            chk(valid == 1'b0, "R9 no pair", int'(valid), 0);
            @(negedge clk);
            chk(busy == 1'b0 && done == 1'b0, "R9 back to idle", int'(busy), 0);
            return;
        end
        while (q_src.size() > 0) begin
            chk(valid == 1'b1, was_stalled ? "R10 valid held" : "R7 valid", int'(valid), 1);
            chk(int'(src_off) == q_src[0], pk ? (up ? "R6 src" : "R4 src") : "R2 src",
                int'(src_off), q_src[0]);
            chk(int'(dst_off) == q_dst[0], up ? (pk ? "R6 dst" : "R5 dst") : "R3 dst",
                int'(dst_off), q_dst[0]);
            chk(last == (q_src.size() == 1), "R8 last flag", int'(last),
                int'(q_src.size() == 1));
            stall = use_stall && (cyc % 3 == 1);
            start = poke && (cyc == 2);          // R11: ignored while busy
            if (poke && cyc == 2) begin
                vl = 6'd1; pack_src = ~pk; unpack_dst = ~up;
            end
            @(posedge clk);
            was_stalled = stall;
            if (!stall) begin
                void'(q_src.pop_front());
                void'(q_dst.pop_front());
            end
            cyc++;
            @(negedge clk);
            start = 1'b0;
        end
        stall = 1'b0;
        chk(done == 1'b1 && valid == 1'b0, poke ? "R11 run unaffected" : "R8 done pulse",
            int'(done), 1);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R8 idle after done", int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(valid == 0 && last == 0 && done == 0 && busy == 0, "R1 reset state",
            int'({valid, last, done, busy}), 0);
        rst_n = 1'b1;
        run_seq(4, 0, 0, 0, 0, 0);   // R2 R3 R7 S=1
        run_seq(2, 2, 1, 0, 0, 0);   // R4 example 0,3,1,4,2,5
        run_seq(3, 3, 0, 1, 1, 0);   // R5 R10
        run_seq(5, 1, 1, 1, 0, 0);   // R6
        run_seq(0, 2, 1, 0, 0, 0);   // R9
        run_seq(1, 3, 1, 0, 0, 0);   // R7 VL=1
        run_seq(4, 1, 1, 0, 1, 1);   // R11 with stalls
        run_seq(63, 3, 1, 1, 1, 0);  // R6 R7 full width
        run_seq(7, 2, 0, 1, 0, 0);   // R5 odd VL
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R8 watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule